// File: doc/BRIEF.md
# Programmable SPI Master Controller

A register-mapped serial master that shifts one word out on `mosi_o` and one word in from `miso_i` for every write to its transmit register. The word length, clock polarity, clock phase, bit order and an internal loopback path are set in a 32-bit mode register. The serial clock comes from `clk_i` through a two-stage divider: an optional fixed divide-by-16 stage followed by a 4-bit multiplier field.

Software programs the mode register with the unit disabled and then sets the enable bit. Each write to the transmit register starts one transfer. When the word has been shifted, a sticky "receive ready" event is raised and the received word can be read, right-justified. Event bits are cleared by writing ones to them. A mask register selects which events drive `irq_o`. Chip selects are outside the block.

Register word addresses on `addr_i`: 0 mode, 1 event, 2 mask, 3 transmit (write), 4 receive (read). Reads are combinational on `addr_i`. Writes take effect on the clock edge where `req_i` and `we_i` are both high.

Top module: `spi_master_ctl`

## Requirements
- R1: After reset the mode register reads 0x2E7F0000, the event register reads 0x00000100, the mask register reads 0, `irq_o` is 0 and `sck_o` is 1.
- R2: Mode fields are laid out as follows. Bit 30 is loopback, bit 29 clock idle high, bit 28 phase, bit 27 divide-by-16, bit 26 MSB first, bit 25 master and bit 24 enable. Bits 23:20 hold the length code and bits 19:16 hold the prescale field PM. While the unit is enabled, a mode write that keeps bit 24 set leaves the register unchanged. A write with bit 24 clear updates every field.
- R3: Length code c from 3 to 15 gives c+1 bits per word, and code 0 gives 32 bits. Codes 1 and 2 give 4 bits. The received word is right-justified, and its unused upper bits read as zero.
- R4: The serial clock period is 4·(PM+1) cycles of `clk_i`. It is 64·(PM+1) cycles when divide-by-16 is set.
- R5: Between words `sck_o` rests at the level of bit 29. With phase 0, data is sampled on the first (leading) edge of each bit. With phase 1, data is driven on the leading edge and sampled on the trailing edge.
- R6: With bit 26 set the word shifts most significant bit first. With bit 26 clear it shifts least significant bit first. This applies to both directions.
- R7: With loopback set, the receiver takes the block's own serial output and ignores `miso_i`.
- R8: Event bit 9 (receive ready) is set when a transfer completes and is cleared by writing 1 to it. Event bit 8 (transmit free) reads 1 whenever no transfer is in progress.
- R9: `irq_o` is high when bit 9 is set in both the event and mask registers, or when bit 8 is set in both.
- R10: Clearing the enable bit stops a transfer in progress, returns `sck_o` to its idle level and does not raise receive ready. After re-enabling, the next transfer is correct.
- R11: A transmit write while the unit is disabled starts no transfer and raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Masked event interrupt |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The bench uses a serial slave that shifts on falling clock edges and a monitor that captures `mosi_o` on rising edges. With these it checks both phase/polarity corners. A design that sampled on the wrong edge would return a word shifted by one bit, and a reversed bit order would show up as a mirrored word on both the line and in the receive register. The lengths at the two ends of the range are checked next. With the 4-bit code, any upper bits left in the received word would appear above the nibble. With code 0, a design that decoded it as one bit, or did not decode it at all, would fail the 32-bit word. Clock-period measurements catch a wrong divide factor. The last group covers aborting a transfer by disabling the unit, mode writes made while enabled, and transmit writes made while disabled. A design that got these wrong would leave the clock stuck at the wrong level, raise a spurious receive event, or change its length in the middle of operation.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int MB_LOOP   = 30;
  localparam int MB_CPOL   = 29;
  localparam int MB_CPHA   = 28;
  localparam int MB_DIV16  = 27;
  localparam int MB_MSB    = 26;
  localparam int MB_EN     = 24;
  localparam int LEN_LSB   = 20;
  localparam int PM_LSB    = 16;
  localparam int EV_RXRDY  = 9;
  localparam int EV_TXFREE = 8;
  localparam logic [31:0] MODE_RST  = 32'h2E7F_0000;
  localparam logic [31:0] MODE_MASK = 32'h7FFF_0000;

  typedef enum logic [2:0] {
    A_MODE  = 3'd0,
    A_EVENT = 3'd1,
    A_MASK  = 3'd2,
    A_TX    = 3'd3,
    A_RX    = 3'd4
  } reg_addr_e;

  // code 0 means 32 bits; codes below 3 are clamped to 4 bits
  function automatic logic [5:0] len_decode(input logic [3:0] code);
    if (code == 4'd0)     return 6'd32;
    else if (code < 4'd3) return 6'd4;
    else                  return {2'b00, code} + 6'd1;
  endfunction
endpackage

// File: rtl/spi_ctl_baud.sv
module spi_ctl_baud #(
  parameter int PM_W    = 4,
  parameter int FIX_DIV = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            div16_i,
  input  logic [PM_W-1:0] pm_i,
  output logic            tick_o
);
  localparam int MAX_HALF = 2 * FIX_DIV * (1 << PM_W);
  localparam int CNT_W    = $clog2(MAX_HALF);

  logic [CNT_W:0]   half_c;
  logic [CNT_W-1:0] limit, cnt_q;

  always_comb begin
    half_c = ((CNT_W+1)'(pm_i) + 1'b1) << 1;
    if (div16_i) half_c = half_c * (CNT_W+1)'(FIX_DIV);
    limit = CNT_W'(half_c - 1'b1);
  end

  assign tick_o = run_i && (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || tick_o)   cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= limit); // R4
endmodule

// File: rtl/spi_ctl_shift.sv
module spi_ctl_shift #(
  parameter int DATA_W = 32,
  localparam int LEN_W  = $clog2(DATA_W) + 1,
  localparam int ECNT_W = LEN_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_word_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              msb_first_i,
  input  logic              cpha_i,
  input  logic              loop_i,
  input  logic              miso_i,
  input  logic              tick_i,
  output logic              busy_o,
  output logic              sck_t_o,
  output logic              mosi_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_word_o
);
  logic [DATA_W-1:0] tx_sr, rx_sr, rx_new, rx_just;
  logic [ECNT_W-1:0] ecnt;
  logic [LEN_W-2:0]  msb_idx;
  logic              din, sample, shift_out, last;

  assign msb_idx   = (LEN_W-1)'(len_i - 1'b1);
  assign mosi_o    = msb_first_i ? tx_sr[msb_idx] : tx_sr[0];
  assign din       = loop_i ? mosi_o : miso_i;
  // even edge index = leading edge
  assign sample    = (ecnt[0] == cpha_i);
  assign shift_out = !sample && !(cpha_i && ecnt == '0);
  assign last      = (ecnt == ({len_i, 1'b0} - 1'b1));

  always_comb begin
    if (!sample)          rx_new = rx_sr;
    else if (msb_first_i) rx_new = {rx_sr[DATA_W-2:0], din};
    else                  rx_new = {din, rx_sr[DATA_W-1:1]};
    rx_just = msb_first_i ? rx_new : (rx_new >> (LEN_W'(DATA_W) - len_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr <= '0; rx_sr <= '0; ecnt <= '0;
      busy_o <= 1'b0; sck_t_o <= 1'b0; done_o <= 1'b0; rx_word_o <= '0;
    end else if (!en_i) begin
      busy_o <= 1'b0; sck_t_o <= 1'b0; ecnt <= '0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_o) begin
        tx_sr  <= tx_word_i;
        rx_sr  <= '0;
        ecnt   <= '0;
        busy_o <= 1'b1;
      end else if (busy_o && tick_i) begin
        sck_t_o <= ~sck_t_o;
        rx_sr   <= rx_new;
        if (shift_out) tx_sr <= msb_first_i ? (tx_sr << 1) : (tx_sr >> 1);
        if (last) begin
          busy_o    <= 1'b0;
          done_o    <= 1'b1;
          rx_word_o <= rx_just;
          ecnt      <= '0;
        end else begin
          ecnt <= ecnt + 1'b1;
        end
      end
    end
  end

  AST_IDLE_SCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sck_t_o); // R5
  AST_EDGE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ecnt < {len_i, 1'b0}); // R3
  AST_STOP_ON_DISABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !busy_o && !done_o); // R10
endmodule

// File: rtl/spi_master_ctl.sv
module spi_master_ctl
  import spi_ctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PM_W   = 4,
  parameter int FIX_DIV = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o,
  output logic        sck_o,
  output logic        mosi_o,
  input  logic        miso_i
);
  localparam int LEN_W = $clog2(DATA_W) + 1;

  logic [31:0]       mode_q, ev_v;
  logic [1:0]        mask_q;
  logic              ev_rx_q, en, busy, sck_t, done, tick, wr;
  logic [DATA_W-1:0] rx_word;
  logic [LEN_W-1:0]  len;

  assign wr  = req_i && we_i;
  assign en  = mode_q[MB_EN];
  assign len = LEN_W'(len_decode(mode_q[LEN_LSB+3:LEN_LSB]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_RST;
      mask_q  <= '0;
      ev_rx_q <= 1'b0;
    end else begin
      // fields locked while running; only clearing enable unlocks them
      if (wr && addr_i == A_MODE && !(en && wdata_i[MB_EN]))
        mode_q <= wdata_i & MODE_MASK;
      if (wr && addr_i == A_MASK)
        mask_q <= wdata_i[EV_RXRDY:EV_TXFREE];
      if (done)
        ev_rx_q <= 1'b1;
      else if (wr && addr_i == A_EVENT && wdata_i[EV_RXRDY])
        ev_rx_q <= 1'b0;
    end
  end

  spi_ctl_baud #(.PM_W(PM_W), .FIX_DIV(FIX_DIV)) u_baud (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (busy),
    .div16_i (mode_q[MB_DIV16]),
    .pm_i    (mode_q[PM_LSB +: PM_W]),
    .tick_o  (tick)
  );

  spi_ctl_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .start_i     (wr && addr_i == A_TX && en),
    .tx_word_i   (wdata_i[DATA_W-1:0]),
    .len_i       (len),
    .msb_first_i (mode_q[MB_MSB]),
    .cpha_i      (mode_q[MB_CPHA]),
    .loop_i      (mode_q[MB_LOOP]),
    .miso_i      (miso_i),
    .tick_i      (tick),
    .busy_o      (busy),
    .sck_t_o     (sck_t),
    .mosi_o      (mosi_o),
    .done_o      (done),
    .rx_word_o   (rx_word)
  );

  assign sck_o = mode_q[MB_CPOL] ^ sck_t;
  assign irq_o = (ev_rx_q && mask_q[1]) || (!busy && mask_q[0]);

  always_comb begin
    ev_v = '0;
    ev_v[EV_RXRDY]  = ev_rx_q;
    ev_v[EV_TXFREE] = !busy;
    case (addr_i)
      A_MODE:  rdata_o = mode_q;
      A_EVENT: rdata_o = ev_v;
      A_MASK:  rdata_o = {22'b0, mask_q, 8'b0};
      A_RX:    rdata_o = 32'(rx_word);
      default: rdata_o = '0;
    endcase
  end

  AST_RXRDY_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> ev_rx_q); // R8
  AST_MODE_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == A_MODE && en && wdata_i[MB_EN]) |=> $stable(mode_q)); // R2
  AST_NO_XFER_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !$past(en)) |-> !busy && !done); // R11
endmodule

// File: tb/spi_master_ctl_tb.sv
module spi_master_ctl_tb;
  logic        clk = 1'b0, rst_ni = 1'b0, req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq, sck, mosi, miso;

  always #10 clk = ~clk;

  spi_master_ctl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .sck_o(sck),
    .mosi_o(mosi), .miso_i(miso)
  );

  int total = 0, bad = 0;
  logic [31:0] slave_sr = '0, mon = '0;
  time t_prev = 0, t_last = 0;

  assign miso = slave_sr[31];
  always @(negedge sck) slave_sr <= slave_sr << 1;
  always @(posedge sck) begin
    mon    <= {mon[30:0], mosi};
    t_prev <= t_last;
    t_last <= $time;
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  function automatic logic [31:0] mv(input bit cpol, cpha, msb, lp, dv,
                                     input logic [3:0] pm, code);
    return {1'b0, lp, cpol, cpha, dv, msb, 1'b1, 1'b0, code, pm, 16'h0};
  endfunction

  task automatic set_mode(input logic [31:0] v);
    bus_wr(3'd0, v);
    bus_wr(3'd0, v | 32'h0100_0000);
  endtask

  task automatic load_slave(input logic [31:0] pat, input int len, input bit cpha);
    slave_sr = pat << (32 - len);
    if (cpha) slave_sr = slave_sr >> 1;
    mon = '0;
  endtask

  task automatic xfer(input logic [31:0] tx, input bit clr, output logic [31:0] rx);
    logic [31:0] ev;
    bit seen = 1'b0;
    bus_wr(3'd3, tx);
    for (int i = 0; i < 20000 && !seen; i++) begin
      bus_rd(3'd1, ev);
      seen = ev[9];
    end
    if (!seen) chk("R8 rx ready timeout", 32'd0, 32'd1);
    bus_rd(3'd4, rx);
    if (clr) bus_wr(3'd1, 32'h0000_0300);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_rd(3'd0, d); chk("R1 mode reset", d, 32'h2E7F_0000);
    bus_rd(3'd1, d); chk("R1 event reset", d, 32'h0000_0100);
    bus_rd(3'd2, d); chk("R1 mask reset", d, 32'h0);
    chk("R1 irq reset", 32'(irq), 32'd0);
    chk("R1 sck reset", 32'(sck), 32'd1);
  endtask

  task automatic t_mode0_msb();
    logic [31:0] rx;
    set_mode(mv(0, 0, 1, 0, 0, 4'd0, 4'd7));
    load_slave(32'h3C, 8, 0);
    xfer(32'hA5, 1, rx);
    chk("R5 mode0 rx", rx, 32'h3C);
    chk("R6 msb-first line", mon & 32'hFF, 32'hA5);
    chk("R5 idle low", 32'(sck), 32'd0);
    chk("R4 period pm0", 32'(t_last - t_prev), 32'd80);
  endtask

  task automatic t_lsb();
    logic [31:0] rx;
    set_mode(mv(0, 0, 0, 0, 0, 4'd1, 4'd7));
    load_slave(32'hC1, 8, 0);
    xfer(32'h1E, 1, rx);
    chk("R6 lsb-first rx", rx, 32'h83);
    chk("R6 lsb-first line", mon & 32'hFF, 32'h78);
    chk("R4 period pm1", 32'(t_last - t_prev), 32'd160);
  endtask

  task automatic t_mode3();
    logic [31:0] rx;
    set_mode(mv(1, 1, 1, 0, 0, 4'd0, 4'd11));
    load_slave(32'hABC, 12, 1);
    xfer(32'h5A3, 1, rx);
    chk("R5 mode3 rx", rx, 32'hABC);
    chk("R5 mode3 line", mon & 32'hFFF, 32'h5A3);
    chk("R5 idle high", 32'(sck), 32'd1);
  endtask

  task automatic t_loop_len();
    logic [31:0] rx;
    set_mode(mv(0, 0, 1, 1, 0, 4'd0, 4'd15));
    load_slave(32'hFFFF_FFFF, 32, 0);
    xfer(32'h1234, 1, rx);
    chk("R7 loopback ignores miso", rx, 32'h1234);
    set_mode(mv(0, 0, 1, 1, 0, 4'd0, 4'd0));
    xfer(32'hDEAD_BEEF, 1, rx);
    chk("R3 code0 is 32 bits", rx, 32'hDEAD_BEEF);
    set_mode(mv(0, 0, 1, 1, 0, 4'd0, 4'd3));
    xfer(32'hFFFF_FFF5, 1, rx);
    chk("R3 4-bit right-justified", rx, 32'h5);
    set_mode(mv(0, 1, 0, 1, 1, 4'd2, 4'd3));
    xfer(32'hA, 1, rx);
    chk("R3 4-bit lsb loop", rx, 32'hA);
    chk("R4 period div16 pm2", 32'(t_last - t_prev), 32'd3840);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    bus_wr(3'd0, mv(0, 0, 1, 1, 0, 4'd0, 4'd7) | 32'h0100_0000);
    bus_rd(3'd0, d);
    chk("R2 locked while enabled", d, mv(0, 1, 0, 1, 1, 4'd2, 4'd3) | 32'h0100_0000);
    bus_wr(3'd0, mv(0, 0, 1, 1, 0, 4'd0, 4'd7));
    bus_rd(3'd0, d);
    chk("R2 write when disabling", d, mv(0, 0, 1, 1, 0, 4'd0, 4'd7));
  endtask

  task automatic t_irq();
    logic [31:0] rx, d;
    set_mode(mv(0, 0, 1, 1, 0, 4'd0, 4'd7));
    bus_wr(3'd2, 32'h200);
    chk("R9 irq low before", 32'(irq), 32'd0);
    xfer(32'h5C, 0, rx);
    chk("R9 irq on rx ready", 32'(irq), 32'd1);
    bus_wr(3'd2, 32'h0);
    chk("R9 masked off", 32'(irq), 32'd0);
    bus_wr(3'd1, 32'h200);
    bus_rd(3'd1, d);
    chk("R8 w1c clears", d, 32'h100);
    bus_wr(3'd2, 32'h100);
    chk("R9 irq on tx free", 32'(irq), 32'd1);
    bus_wr(3'd2, 32'h0);
  endtask

  task automatic t_disable();
    logic [31:0] rx, d;
    set_mode(mv(0, 0, 1, 0, 1, 4'd15, 4'd15));
    bus_wr(3'd3, 32'hFFFF);
    repeat (1500) @(negedge clk);
    bus_rd(3'd1, d);
    chk("R8 busy clears tx free", d, 32'h0);
    bus_wr(3'd0, mv(0, 0, 1, 0, 1, 4'd15, 4'd15));
    repeat (2) @(negedge clk);
    chk("R10 sck idle after abort", 32'(sck), 32'd0);
    bus_rd(3'd1, d);
    chk("R10 no rx ready after abort", d, 32'h100);
    set_mode(mv(0, 0, 1, 1, 0, 4'd0, 4'd7));
    xfer(32'h96, 1, rx);
    chk("R10 clean after re-enable", rx, 32'h96);
  endtask

  task automatic t_tx_off();
    logic [31:0] d;
    bus_wr(3'd0, mv(0, 0, 1, 1, 0, 4'd0, 4'd7));
    bus_wr(3'd3, 32'h77);
    repeat (60) @(negedge clk);
    bus_rd(3'd1, d);
    chk("R11 tx write while disabled", d, 32'h100);
    chk("R11 sck stays idle", 32'(sck), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_mode0_msb();
    t_lsb();
    t_mode3();
    t_loop_len();
    t_lock();
    t_irq();
    t_disable();
    t_tx_off();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule